// File: doc/BRIEF.md
# Spin Lock Requester with Read Pre-Check and Exponential Backoff

This block sits beside one CPU and acquires a lock word in shared memory for it. On an acquire command it latches the lock address and begins polling. With the pre-check enabled, each poll is a plain read, and an atomic test-and-set is issued only after a read returns zero. With the pre-check disabled, each poll is a test-and-set. A zero returned by the test-and-set means the lock is owned, and the block raises `acquired_o` until a release command. The release is a single write of zero to the lock word.

A read that returns zero only suggests the lock is free. If the test-and-set that follows returns nonzero, another requester won, and the attempt counts as a failed poll. After every failed poll the block waits before polling again. The first wait is one cycle, and the wait doubles after each further failure until it reaches the ceiling `2**MAX_LOG2`. A successful acquisition sets the wait back to one cycle. Memory operations go to an arbiter upstream through a request that is held until acknowledged. The acknowledge carries the returned lock word.

Top module: `spin_lock_requester`

## Requirements
- R1: After reset the block is idle: `mem_req_o` is 0, `mem_op_o` is 0 (none) and `acquired_o` is 0.
- R2: With `precheck_en_i` high at the acquire, every poll is a read (`mem_op_o` = 1). No test-and-set is issued after a read that returns a nonzero word.
- R3: A read that returns zero is followed, in the next cycle, by a test-and-set request (`mem_op_o` = 2) to the same address.
- R4: `acquired_o` rises only in the cycle after a test-and-set is acknowledged with a zero word. It then stays high, with no memory request, until `release_i`.
- R5: A test-and-set acknowledged with a nonzero word is a failed attempt. No request is made in the next cycle, `acquired_o` stays low, and polling resumes after the wait.
- R6: After a failed poll, the request line stays low for exactly W cycles before the next poll. W is 1 after the first failure and doubles after each further failure (1, 2, 4, ...).
- R7: W saturates at `2**MAX_LOG2` (16 by default) and stays there for any later failure.
- R8: With `precheck_en_i` low at the acquire, every poll is a test-and-set, and the same backoff applies between failures.
- R9: `release_i` in the held state issues a clear-to-zero write (`mem_op_o` = 3) to the lock address. After its acknowledge the block is idle, with `acquired_o` low.
- R10: The wait returns to 1 cycle after each successful acquisition, so the first failure of the next acquisition waits 1 cycle.
- R11: A request holds `mem_op_o` and `mem_addr_o` stable until `mem_ack_i`. `mem_addr_o` is the address latched at the acquire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acquire_i | input | 1 | Start acquisition (sampled when idle) |
| release_i | input | 1 | Release lock (sampled when held) |
| precheck_en_i | input | 1 | 1: poll with plain reads, 0: poll with test-and-set; latched at acquire |
| lock_addr_i | input | AW | Lock word address, latched at acquire |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_op_o | output | 2 | 0 none, 1 read, 2 test-and-set, 3 write zero |
| mem_addr_o | output | AW | Address of the request |
| mem_ack_i | input | 1 | Request accepted and completed this cycle |
| mem_rdata_i | input | DW | Lock word returned with the acknowledge |
| acquired_o | output | 1 | Lock is held |

## Verification
The bench drives a run of busy reads long enough to pass the ceiling. It measures every idle gap on the request line, which catches a wait that starts at two cycles, doubles one step late, or wraps or keeps growing past the cap. A run of a free read followed by a losing test-and-set checks that the free read is treated only as a hint: a design that granted on the read would raise `acquired_o` early. A run with the pre-check disabled checks that no read is issued and that the backoff still applies. Back-to-back acquisitions check that the wait is set back to one cycle, since a design that kept the wait would show a long first gap.

// File: rtl/spin_lock_pkg.sv
package spin_lock_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_TAS, ST_WAIT, ST_HELD, ST_RELEASE
  } lk_state_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_TAS   = 2'd2,
    OP_CLEAR = 2'd3
  } mem_op_e;
endpackage

// File: rtl/spin_lock_backoff.sv
module spin_lock_backoff #(
  parameter int MAX_LOG2 = 4,
  localparam int CW = MAX_LOG2 + 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clear_i,
  output logic done_o
);
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] WMAX = ONE << MAX_LOG2;

  logic [CW-1:0] delay_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] delay_nxt;

  // double, then saturate at the ceiling
  assign delay_nxt = (delay_q >= WMAX) ? WMAX : (delay_q << 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delay_q <= ONE;
      cnt_q   <= '0;
    end else begin
      if (clear_i)      delay_q <= ONE;
      else if (start_i) delay_q <= delay_nxt;
      if (start_i)          cnt_q <= delay_q;
      else if (cnt_q != '0) cnt_q <= cnt_q - ONE;
    end
  end

  assign done_o = (cnt_q == ONE);
endmodule

// File: rtl/spin_lock_fsm.sv
module spin_lock_fsm
  import spin_lock_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acquire_i,
  input  logic          release_i,
  input  logic          precheck_en_i,
  input  logic [AW-1:0] lock_addr_i,
  input  logic          mem_ack_i,
  input  logic          word_free_i,
  input  logic          wait_done_i,
  output lk_state_e     state_o,
  output logic [AW-1:0] addr_o,
  output logic          bo_start_o,
  output logic          bo_clear_o
);
  lk_state_e     st_q, st_d;
  logic          pre_q;
  logic [AW-1:0] addr_q;

  always_comb begin
    st_d       = st_q;
    bo_start_o = 1'b0;
    bo_clear_o = 1'b0;
    unique case (st_q)
      ST_IDLE:    if (acquire_i) st_d = precheck_en_i ? ST_READ : ST_TAS;
      ST_READ: begin
        if (mem_ack_i) begin
          if (word_free_i) st_d = ST_TAS;
          else begin
            st_d       = ST_WAIT;
            bo_start_o = 1'b1;
          end
        end
      end
      ST_TAS: begin
        if (mem_ack_i) begin
          if (word_free_i) begin
            st_d       = ST_HELD;
            bo_clear_o = 1'b1;
          end else begin
            st_d       = ST_WAIT;
            bo_start_o = 1'b1;
          end
        end
      end
      ST_WAIT:    if (wait_done_i) st_d = pre_q ? ST_READ : ST_TAS;
      ST_HELD:    if (release_i) st_d = ST_RELEASE;
      ST_RELEASE: if (mem_ack_i) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pre_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && acquire_i) begin
        pre_q  <= precheck_en_i;
        addr_q <= lock_addr_i;
      end
    end
  end

  assign state_o = st_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/spin_lock_requester.sv
module spin_lock_requester
  import spin_lock_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int MAX_LOG2 = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acquire_i,
  input  logic          release_i,
  input  logic          precheck_en_i,
  input  logic [AW-1:0] lock_addr_i,
  output logic          mem_req_o,
  output logic [1:0]    mem_op_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          acquired_o
);
  lk_state_e state;
  logic      word_free;
  logic      bo_start, bo_clear, bo_done;

  assign word_free = (mem_rdata_i == '0);

  spin_lock_fsm #(.AW(AW)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .acquire_i     (acquire_i),
    .release_i     (release_i),
    .precheck_en_i (precheck_en_i),
    .lock_addr_i   (lock_addr_i),
    .mem_ack_i     (mem_ack_i),
    .word_free_i   (word_free),
    .wait_done_i   (bo_done),
    .state_o       (state),
    .addr_o        (mem_addr_o),
    .bo_start_o    (bo_start),
    .bo_clear_o    (bo_clear)
  );

  spin_lock_backoff #(.MAX_LOG2(MAX_LOG2)) u_backoff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (bo_start),
    .clear_i (bo_clear),
    .done_o  (bo_done)
  );

  always_comb begin
    mem_req_o = 1'b1;
    unique case (state)
      ST_READ:    mem_op_o = OP_READ;
      ST_TAS:     mem_op_o = OP_TAS;
      ST_RELEASE: mem_op_o = OP_CLEAR;
      default: begin
        mem_op_o  = OP_NONE;
        mem_req_o = 1'b0;
      end
    endcase
  end

  assign acquired_o = (state == ST_HELD);
endmodule

// File: rtl/spin_lock_requester_chk.sv
module spin_lock_requester_chk #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int MAX_LOG2 = 4,
  localparam int CW = MAX_LOG2 + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic [1:0]    mem_op_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic [DW-1:0] mem_rdata_i,
  input logic          acquired_o,
  input logic [CW-1:0] delay_i
);
  localparam logic [CW-1:0] WMAX = {{(CW-1){1'b0}}, 1'b1} << MAX_LOG2;

  logic rd_ack, tas_ack, clr_ack;
  assign rd_ack  = mem_req_o && mem_ack_i && mem_op_o == 2'd1;
  assign tas_ack = mem_req_o && mem_ack_i && mem_op_o == 2'd2;
  assign clr_ack = mem_req_o && mem_ack_i && mem_op_o == 2'd3;

  a_r2_no_tas_after_busy_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack && mem_rdata_i != '0 |=> !mem_req_o);

  a_r3_tas_after_free_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ack && mem_rdata_i == '0 |=> mem_req_o && mem_op_o == 2'd2 && $stable(mem_addr_o));

  a_r4_grant_from_tas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acquired_o) |-> $past(tas_ack && mem_rdata_i == '0));

  a_r4_held_is_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acquired_o |-> !mem_req_o);

  a_r5_failed_tas_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tas_ack && mem_rdata_i != '0 |=> !mem_req_o && !acquired_o);

  a_r7_delay_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_i <= WMAX && delay_i != '0);

  a_r9_release_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ack |=> !mem_req_o && !acquired_o);

  a_r11_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_op_o) && $stable(mem_addr_o));
endmodule

bind spin_lock_requester spin_lock_requester_chk #(
  .AW(AW), .DW(DW), .MAX_LOG2(MAX_LOG2)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_op_o    (mem_op_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .mem_rdata_i (mem_rdata_i),
  .acquired_o  (acquired_o),
  .delay_i     (u_backoff.delay_q)
);

// File: tb/spin_lock_requester_bench.sv
`timescale 1ns/1ps
module spin_lock_requester_bench;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int MAX_LOG2 = 4;
  localparam int MAXD = 1 << MAX_LOG2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          acquire_i = 1'b0;
  logic          release_i = 1'b0;
  logic          precheck_en_i = 1'b0;
  logic [AW-1:0] lock_addr_i = '0;
  logic          mem_req_o;
  logic [1:0]    mem_op_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_ack_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          acquired_o;

  spin_lock_requester #(.AW(AW), .DW(DW), .MAX_LOG2(MAX_LOG2)) u_spin_lock_requester (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // scripted memory responses
  int rd_q[$], tas_q[$];
  int ack_lat = 1;
  int wcnt = 0;
  int ops_seen[$];
  int addr_seen[$];
  int gaps[$];
  bit in_acq = 0, seen_req = 0;
  int gap_run = 0;

  // behavioural reference: 0 idle,1 read,2 tas,3 wait,4 held,5 release
  int m_st = 0, m_delay = 1, m_cnt = 0, m_addr = 0;
  bit m_pre = 0;

  task automatic m_fail_poll();
    m_cnt = m_delay;
    m_delay = (m_delay * 2 > MAXD) ? MAXD : m_delay * 2;
    m_st = 3;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_delay = 1; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (acquire_i) begin
             m_pre = precheck_en_i; m_addr = lock_addr_i; m_st = m_pre ? 1 : 2;
           end
        1: if (mem_ack_i) begin
             if (mem_rdata_i == 0) m_st = 2; else m_fail_poll();
           end
        2: if (mem_ack_i) begin
             if (mem_rdata_i == 0) begin m_st = 4; m_delay = 1; end
             else m_fail_poll();
           end
        3: if (m_cnt == 1) m_st = m_pre ? 1 : 2; else m_cnt--;
        4: if (release_i) m_st = 5;
        5: if (mem_ack_i) m_st = 0;
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      int e_op;
      e_op = (m_st == 1) ? 1 : (m_st == 2) ? 2 : (m_st == 5) ? 3 : 0;
      check(mem_req_o == (e_op != 0), "R2 req", mem_req_o, e_op != 0);
      check(mem_op_o == e_op, "R8 op", mem_op_o, e_op);
      check(acquired_o == (m_st == 4), "R4 acquired", acquired_o, m_st == 4);
      if (e_op != 0) check(mem_addr_o == m_addr, "R11 addr", mem_addr_o, m_addr);
      // gap measurement
      if (in_acq) begin
        if (mem_req_o) begin
          if (gap_run > 0) gaps.push_back(gap_run);
          gap_run = 0; seen_req = 1;
        end else if (seen_req && !acquired_o) gap_run++;
      end
      // acknowledge driver
      if (mem_ack_i) begin
        mem_ack_i = 0; wcnt = 0;
      end else if (mem_req_o) begin
        wcnt++;
        if (wcnt >= ack_lat) begin
          mem_ack_i = 1;
          ops_seen.push_back(mem_op_o);
          addr_seen.push_back(mem_addr_o);
          if (mem_op_o == 2'd1)      mem_rdata_i = rd_q.size() ? DW'(rd_q.pop_front()) : '0;
          else if (mem_op_o == 2'd2) mem_rdata_i = tas_q.size() ? DW'(tas_q.pop_front()) : '0;
          else                       mem_rdata_i = '0;
        end
      end
    end
  end

  task automatic do_acquire(input bit pre, input int addr);
    gaps.delete(); ops_seen.delete(); addr_seen.delete();
    gap_run = 0; seen_req = 0;
    @(posedge clk_i); #1;
    acquire_i = 1; precheck_en_i = pre; lock_addr_i = AW'(addr); in_acq = 1;
    @(posedge clk_i); #1;
    acquire_i = 0; lock_addr_i = '1;
    for (int i = 0; i < 3000 && !acquired_o; i++) @(negedge clk_i);
    in_acq = 0;
  endtask

  task automatic do_release(input int addr);
    ops_seen.delete(); addr_seen.delete();
    @(posedge clk_i); #1; release_i = 1;
    @(posedge clk_i); #1; release_i = 0;
    for (int i = 0; i < 50 && (mem_req_o || acquired_o); i++) @(negedge clk_i);
    check(ops_seen.size() == 1 && ops_seen[0] == 3, "R9 clear op", ops_seen.size() ? ops_seen[0] : -1, 3);
    check(addr_seen.size() == 1 && addr_seen[0] == addr, "R9 clear addr",
          addr_seen.size() ? addr_seen[0] : -1, addr);
    check(!acquired_o && !mem_req_o, "R9 idle after release", acquired_o, 0);
  endtask

  task automatic check_gaps(input string req, input int exp[$]);
    check(gaps.size() == exp.size(), {req, " gap count"}, gaps.size(), exp.size());
    foreach (exp[i]) begin
      int a;
      a = (i < gaps.size()) ? gaps[i] : -1;
      check(a == exp[i], req, a, exp[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int ex[$];
    repeat (3) @(posedge clk_i);
    #1;
    // R1: reset state
    check(mem_req_o == 0, "R1 req", mem_req_o, 0);
    check(mem_op_o == 0, "R1 op", mem_op_o, 0);
    check(acquired_o == 0, "R1 acquired", acquired_o, 0);
    rst_ni = 1;
    repeat (2) @(posedge clk_i);

    // R6 R7: six busy reads then free read and won TAS
    ack_lat = 1;
    rd_q = '{1, 1, 1, 1, 1, 1, 0}; tas_q = '{0};
    do_acquire(1, 16'h1a40);
    check(acquired_o == 1, "R4 granted", acquired_o, 1);
    ex = '{1, 2, 4, 8, MAXD, MAXD};
    check_gaps("R7 gaps", ex);
    check(ops_seen.size() == 8, "R2 op count", ops_seen.size(), 8);
    for (int i = 0; i < 7 && i < ops_seen.size(); i++)
      check(ops_seen[i] == 1, "R2 read poll", ops_seen[i], 1);
    if (ops_seen.size() == 8) check(ops_seen[7] == 2, "R3 tas after free", ops_seen[7], 2);
    repeat (7) @(negedge clk_i);
    check(acquired_o == 1 && mem_req_o == 0, "R4 held quiet", acquired_o, 1);
    do_release(16'h1a40);

    // R5 R10: free read, lost TAS, then win; wait must be 1 again
    ack_lat = 3;
    rd_q = '{0, 0}; tas_q = '{5, 0};
    do_acquire(1, 16'h0304);
    check(acquired_o == 1, "R5 granted after retry", acquired_o, 1);
    ex = '{1};
    check_gaps("R10 gaps", ex);
    check(ops_seen.size() == 4, "R5 op count", ops_seen.size(), 4);
    if (ops_seen.size() == 4)
      check(ops_seen[0] == 1 && ops_seen[1] == 2 && ops_seen[2] == 1 && ops_seen[3] == 2,
            "R5 sequence", ops_seen[2], 1);
    do_release(16'h0304);

    // R8: pre-check off, three lost TAS then win
    ack_lat = 2;
    rd_q = '{7}; tas_q = '{3, 3, 3, 0};
    do_acquire(0, 16'hbeef);
    check(acquired_o == 1, "R8 granted", acquired_o, 1);
    ex = '{1, 2, 4};
    check_gaps("R6 gaps", ex);
    check(ops_seen.size() == 4, "R8 op count", ops_seen.size(), 4);
    foreach (ops_seen[i]) check(ops_seen[i] == 2, "R8 tas only", ops_seen[i], 2);
    do_release(16'hbeef);

    repeat (5) @(posedge clk_i);
    finish_run();
  end
endmodule